// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a high-rate clock by a software-chosen integer N and emits one pulse per completed division cycle. A phase-locked loop uses it on its feedback path, and the pulse goes to the phase detector. Inside, a prescaler counts input clocks in cycles of a selectable modulus. A main counter counts prescaler cycles, and a swallow counter decides which prescaler cycles use the larger modulus. In this model each rising edge of `clk` is one cycle of the divided clock.

A 3-bit mode code picks either a plain fixed prescaler ratio F (1, 2 or 3) or a pair P/(P+1) with P equal to 2, 4, 8, 16 or 32. A bypass bit reduces the fixed-ratio divider to the bare prescaler. Settings are written through a single-cycle load strobe. A load that passes the checks is kept in a shadow register and becomes active only at the end of the division cycle in progress. A load that fails the checks is rejected and raises an error flag. The settings are control pins, so there is no valid/ready handshake and no back-pressure: a load is always taken in the cycle its strobe is high.

Top module: `dmd_divider`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `cfg_err` are 0. After reset the active ratio is N=1, so `fb_pulse` is high on every clock.
- R2: Mode codes 000, 001 and 010 select fixed ratio F = 1, 2 or 3. With `cfg_bypass`=0 the divider gives N = F × B.
- R3: In a fixed mode with `cfg_bypass`=1, N = F and the B value has no effect, including B=0.
- R4: Mode codes 011, 100, 101, 110 and 111 select P = 2, 4, 8, 16 and 32. The divider gives N = P × B + A, with P+1 used for the first A prescaler cycles of each division cycle and P for the rest.
- R5: In a dual-modulus mode, `cfg_bypass` has no effect on N.
- R6: The edge values A=0 (N = P×B) and A=B (N = (P+1)×B) divide correctly.
- R7: A load is rejected and `cfg_err` becomes 1 in the cycle after the strobe when either of these holds: a dual-modulus mode with A > B or B = 0, or a fixed mode with bypass off and B = 0. A rejected load leaves N unchanged. The next accepted load clears `cfg_err`.
- R8: An accepted load takes effect only after the division cycle in progress has ended. That cycle keeps its old length, and the cycles after it use the new N.
- R9: `fb_pulse` is high for exactly one clock per division cycle, and consecutive rising edges of `fb_pulse` are N clocks apart.
- R10: In a fixed mode the A value has no effect on N and does not cause an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock, one count per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that captures the setting inputs |
| cfg_mode | input | 3 | Prescaler mode code (see R2, R4) |
| cfg_bypass | input | 1 | Reduces a fixed mode to the bare prescaler |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| fb_pulse | output | 1 | One pulse per completed division cycle |
| cfg_err | output | 1 | The last load was rejected |

## Verification
The embedded properties check several things on every cycle. The swallow count never exceeds the remaining main count in a dual-modulus cycle. The prescaler count stays within the largest modulus, and the main count never reaches zero. The error flag rises only after a load, and a rejected load leaves the shadow settings untouched. The pulse follows a prescaler terminal. The exact division ratio for each mode, the bypass and don't-care cases, and the rule that a new setting waits for the end of the current cycle are shown only by the bench's scenarios. A scoreboard there compares measured pulse spacing against ratios computed from the requirements.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int MODE_W = 3;
  localparam int MOD_W  = 6;   // holds the largest modulus, 33

  typedef enum logic [MODE_W-1:0] {
    PS_FIX1 = 3'd0, PS_FIX2 = 3'd1, PS_FIX3 = 3'd2,
    PS_DM2  = 3'd3, PS_DM4  = 3'd4, PS_DM8  = 3'd5,
    PS_DM16 = 3'd6, PS_DM32 = 3'd7
  } ps_mode_e;

  function automatic logic is_fixed(input logic [MODE_W-1:0] m);
    return m < PS_DM2;
  endfunction

  // Fixed ratio F for fixed modes, lower modulus P for dual-modulus modes
  function automatic logic [MOD_W-1:0] base_mod(input logic [MODE_W-1:0] m);
    logic [MOD_W-1:0] r;
    if (is_fixed(m)) r = MOD_W'(m) + MOD_W'(1);
    else             r = MOD_W'(2) << (m - PS_DM2);
    return r;
  endfunction
endpackage

// File: rtl/dmd_cfg_reg.sv
module dmd_cfg_reg
  import dmd_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              in_byp,
  input  logic [AW-1:0]     in_a,
  input  logic [BW-1:0]     in_b,
  output logic [MODE_W-1:0] sh_mode,
  output logic              sh_byp,
  output logic [AW-1:0]     sh_a,
  output logic [BW-1:0]     sh_b,
  output logic              err
);
  logic bad;

  always_comb begin
    if (is_fixed(in_mode)) bad = !in_byp && (in_b == '0);
    else                   bad = (BW'(in_a) > in_b) || (in_b == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_mode <= PS_FIX1;
      sh_byp  <= 1'b1;
      sh_a    <= '0;
      sh_b    <= BW'(1);
      err     <= 1'b0;
    end else if (load) begin
      err <= bad;
      if (!bad) begin
        sh_mode <= in_mode;
        sh_byp  <= in_byp;
        sh_a    <= in_a;
        sh_b    <= in_b;
      end
    end
  end

  // R7: the flag only rises as a result of a load
  p_err_from_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(load));

  // R7: a rejected load leaves the shadow settings untouched
  p_reject_keeps_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && bad) |=> ($stable(sh_mode) && $stable(sh_byp) && $stable(sh_a) && $stable(sh_b)));
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] reload,   // modulus of the prescaler cycle that starts next
  output logic          tc
);
  logic [MW-1:0] cnt;

  assign tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (tc) cnt <= reload - MW'(1);
    else         cnt <= cnt - MW'(1);
  end

  // R4: the count never exceeds the largest modulus minus one
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MW'(32));
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow
  import dmd_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 13,
  parameter int MW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tc,
  input  logic [MODE_W-1:0] sh_mode,
  input  logic              sh_byp,
  input  logic [AW-1:0]     sh_a,
  input  logic [BW-1:0]     sh_b,
  output logic              n_term,
  output logic [MW-1:0]     next_mod
);
  logic [MODE_W-1:0] act_mode;
  logic [AW-1:0]     a_rem;
  logic [BW-1:0]     b_rem;
  logic [MODE_W-1:0] nx_mode;
  logic [AW-1:0]     nx_a;
  logic [BW-1:0]     nx_b;

  assign n_term = tc && (b_rem == BW'(1));

  // State that holds after the prescaler cycle now ending
  always_comb begin
    if (n_term) begin
      nx_mode = sh_mode;
      nx_b    = (is_fixed(sh_mode) && sh_byp) ? BW'(1) : sh_b;
      nx_a    = is_fixed(sh_mode) ? '0 : sh_a;
    end else begin
      nx_mode = act_mode;
      nx_b    = b_rem - BW'(1);
      nx_a    = (a_rem != '0) ? a_rem - AW'(1) : '0;
    end
    if (is_fixed(nx_mode)) next_mod = MW'(base_mod(nx_mode));
    else                   next_mod = MW'(base_mod(nx_mode)) + MW'(nx_a != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mode <= PS_FIX1;
      a_rem    <= '0;
      b_rem    <= BW'(1);
    end else if (tc) begin
      act_mode <= nx_mode;
      a_rem    <= nx_a;
      b_rem    <= nx_b;
    end
  end

  // R6: swallow cycles left never exceed main cycles left
  p_swallow_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fixed(act_mode) |-> (BW'(a_rem) <= b_rem));

  // R7: rejected settings keep the main count from ever reaching zero
  p_main_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_rem != '0);
endmodule

// File: rtl/dmd_divider.sv
module dmd_divider
  import dmd_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 13,
  parameter int MW = MOD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_bypass,
  input  logic [AW-1:0] cfg_a,
  input  logic [BW-1:0] cfg_b,
  output logic          fb_pulse,
  output logic          cfg_err
);
  logic [MODE_W-1:0] sh_mode;
  logic              sh_byp;
  logic [AW-1:0]     sh_a;
  logic [BW-1:0]     sh_b;
  logic              psc_tc;
  logic              n_term;
  logic [MW-1:0]     next_mod;
  logic              pulse_q;

  dmd_cfg_reg #(.AW(AW), .BW(BW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .in_mode(cfg_mode), .in_byp(cfg_bypass), .in_a(cfg_a), .in_b(cfg_b),
    .sh_mode(sh_mode), .sh_byp(sh_byp), .sh_a(sh_a), .sh_b(sh_b),
    .err(cfg_err)
  );

  dmd_swallow #(.AW(AW), .BW(BW), .MW(MW)) u_swl (
    .clk(clk), .rst_n(rst_n), .tc(psc_tc),
    .sh_mode(sh_mode), .sh_byp(sh_byp), .sh_a(sh_a), .sh_b(sh_b),
    .n_term(n_term), .next_mod(next_mod)
  );

  dmd_prescaler #(.MW(MW)) u_psc (
    .clk(clk), .rst_n(rst_n), .reload(next_mod), .tc(psc_tc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= n_term;
  end

  assign fb_pulse = pulse_q;

  // R9: every output pulse follows a prescaler terminal count
  p_pulse_after_tc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(psc_tc));
endmodule

// File: tb/dmd_divider_test.sv
`timescale 1ns/1ps
module dmd_divider_test;
  localparam int AW = 6;
  localparam int BW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [2:0]    cfg_mode = '0;
  logic          cfg_bypass = 1'b0;
  logic [AW-1:0] cfg_a = '0;
  logic [BW-1:0] cfg_b = '0;
  logic          fb_pulse;
  logic          cfg_err;

  always #2.5 clk = ~clk;

  dmd_divider #(.AW(AW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_bypass(cfg_bypass), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  typedef struct {int n; string tag;} exp_t;
  exp_t   exp_q[$];
  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  longint last_pulse = -1;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: measures spacing of pulses and compares with the scoreboard
  always @(negedge clk) begin
    exp_t e;
    int   gap;
    if (rst_n && fb_pulse) begin
      if (last_pulse >= 0 && exp_q.size() > 0) begin
        e   = exp_q.pop_front();
        gap = int'(cyc - last_pulse);
        checks++;
        if (gap != e.n) begin
          errors++;
          $display("FAIL %s: pulse spacing actual %0d expected %0d", e.tag, gap, e.n);
        end
      end
      last_pulse = cyc;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_n(int mode, int byp, int a, int b);
    int p;
    if (mode < 3) return (byp != 0) ? (mode + 1) : (mode + 1) * b;
    p = 2 << (mode - 3);
    return p * b + a;
  endfunction

  task automatic load_cfg(int mode, int byp, int a, int b);
    @(negedge clk);
    cfg_mode = 3'(mode); cfg_bypass = 1'(byp); cfg_a = AW'(a); cfg_b = BW'(b);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic push_n(int n, string tag, int k);
    exp_t e;
    e.n = n; e.tag = tag;
    for (int i = 0; i < k; i++) exp_q.push_back(e);
  endtask

  // Driver: load, wait for the boundary, then expect k periods of the new ratio
  task automatic run_cfg(string tag, int mode, int byp, int a, int b, int k);
    load_cfg(mode, byp, a, b);
    chk(tag, "cfg_err after accepted load", int'(cfg_err), 0);
    wait_pulse();
    @(posedge clk);
    push_n(exp_n(mode, byp, a, b), tag, k);
    repeat (k) wait_pulse();
  endtask

  task automatic bad_cfg(int mode, int byp, int a, int b, int old_n);
    load_cfg(mode, byp, a, b);
    chk("R7", "cfg_err after rejected load", int'(cfg_err), 1);
    wait_pulse();
    @(posedge clk);
    push_n(old_n, "R7", 3);
    repeat (3) wait_pulse();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "fb_pulse in reset", int'(fb_pulse), 0);
    chk("R1", "cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    wait_pulse();
    @(posedge clk);
    push_n(1, "R1", 4);
    repeat (4) wait_pulse();

    // R2: fixed ratios times B
    run_cfg("R2", 0, 0, 0, 5, 3);
    wait_pulse();
    @(negedge clk);
    chk("R9", "fb_pulse one cycle after pulse", int'(fb_pulse), 0);
    run_cfg("R2", 1, 0, 0, 7, 3);
    run_cfg("R2", 2, 0, 0, 3, 3);

    // R3: bypass makes the prescaler alone set N, B ignored even when 0
    run_cfg("R3", 2, 1, 0, 77, 3);
    run_cfg("R3", 1, 1, 0, 0, 3);

    // R10: A ignored in fixed mode, even A > B
    run_cfg("R10", 1, 0, 9, 4, 3);

    // R4: every dual-modulus pair
    run_cfg("R4", 3, 0, 2, 3, 3);
    run_cfg("R4", 4, 0, 3, 5, 3);
    run_cfg("R4", 5, 0, 1, 2, 3);
    // R6: A=0 and A=B edges
    run_cfg("R6", 6, 0, 0, 3, 2);
    run_cfg("R6", 7, 0, 2, 2, 2);

    // R5: bypass has no effect in dual-modulus mode
    run_cfg("R5", 4, 1, 1, 2, 3);

    // R7: rejected loads keep N=9
    bad_cfg(4, 0, 5, 3, 9);
    bad_cfg(0, 0, 0, 0, 9);
    bad_cfg(3, 1, 0, 0, 9);
    run_cfg("R7", 0, 0, 0, 6, 2);

    // R8: load in mid-cycle; the running cycle keeps its old length
    wait_pulse();
    @(posedge clk);
    push_n(6, "R8", 1);
    load_cfg(2, 0, 0, 4);
    wait_pulse();
    @(posedge clk);
    push_n(12, "R8", 2);
    repeat (2) wait_pulse();

    // R9: spacing under a long dual-modulus ratio
    run_cfg("R9", 5, 0, 7, 9, 2);

    @(negedge clk);
    chk("R9", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule